// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps calendar time (seconds, minutes, hours, day of week, date, month and year) as binary-coded decimal inside a small byte-wide register file. Software reads and writes it one byte at a time through an address/data port. A single-cycle `sec_tick` pulse, produced elsewhere once per second, advances the time. Carries run through minutes, hours, days, months and years, and take account of month lengths and leap years.

Writes to time fields are screened one field at a time. A value whose digits are not valid BCD, or which lies outside the field's range, is dropped without any side effect. A hold flag kept in the top bit of the seconds register freezes the clock. The control register always reads back with certain bits forced. The `YEAR_BASE` parameter sets which century the two-digit year belongs to, and this decides whether year 00 is a leap year.

Top module: `rtc_bcd_regs`

## Requirements
- R1: After reset the registers read control 0x90, seconds 0x00 with hold clear, minutes 0x00, hours 0x00, day/century 0x00, date 0x01, month 0x01, year 0x00.
- R2: Register indices are 0 control, 1 seconds, 2 minutes, 3 hours, 4 day/century, 5 date, 6 month, 7 year. Any address of 8 or above reads 0x00, and a write to it changes nothing.
- R3: A control write stores the data with bits 7 and 5 cleared, then bits 7 and 4 set.
- R4: Every seconds write copies data bit 7 into the hold flag. While the flag is set, ticks do nothing. Clearing it resumes counting from the held value. The seconds register reads back as {hold, BCD seconds[6:0]}.
- R5: Seconds and minutes writes take data[6:0] and are accepted only for valid BCD 00 to 59. Hours writes take data[5:0] and are accepted only for 00 to 23.
- R6: Date writes take data[5:0] and are accepted for 01 to 31. Month writes take data[4:0] and are accepted for 01 to 12. Year writes take all 8 bits and are accepted when both digits are 0 to 9. A rejected write leaves the field unchanged.
- R7: A day/century write stores day of week from data[2:0] and a century flag from data[6]. A read returns {0, century, 000, day}.
- R8: On a tick with hold clear, seconds advance. 59 rolls to 00 and carries into minutes. Minutes 59 carry into hours. Hours 23 roll to 00 and advance both the date and the day of week. The day of week counts 0 to 6, and a value of 6 or 7 wraps to 0. Time changes only on a tick or a write.
- R9: On a day carry, a date at or past the current month's length goes back to 01 and the month advances. The lengths are 28 (or 29 in a leap year) for month 02, 30 for months 04, 06, 09 and 11, and 31 for the rest. A leap year is a year value divisible by 4.
- R10: Month 12 rolls over to 01 and advances the year. Year 99 rolls over to 00. The century flag is never changed by counting.
- R11: With `YEAR_BASE` 1900, year 00 is not a leap year. With 1968, it is.
- R12: When a tick and a write land in the same cycle, the tick is applied first and an accepted write then overrides its own field.
- R13: Every BCD digit of every time field always stays within 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Register index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read of the register at `addr` |

## Verification
The counting path and the write path can act in the same cycle. When that happens, the tick's carries ripple through the other fields while the written field takes the written value. The bench provokes this directly, with a minutes write landing on the tick that wraps seconds. Random cycles also assert `sec_tick` and `wr_en` together often. A reference model applies the tick first and the screened write second, and every register is read back and compared after each cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef enum logic [2:0] {
      RG_CTRL = 3'd0,
      RG_SEC  = 3'd1,
      RG_MIN  = 3'd2,
      RG_HOUR = 3'd3,
      RG_DAY  = 3'd4,
      RG_DATE = 3'd5,
      RG_MON  = 3'd6,
      RG_YEAR = 3'd7
   } rtc_reg_e;

   // counted field slots, least significant first (carry order)
   localparam int FI_SEC  = 0;
   localparam int FI_MIN  = 1;
   localparam int FI_HOUR = 2;
   localparam int FI_DATE = 3;
   localparam int FI_MON  = 4;
   localparam int FI_YEAR = 5;
   localparam int N_FIELD = 6;

   function automatic logic bcd_digits_ok(input logic [7:0] v);
      return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
   endfunction

   function automatic logic [7:0] bcd_step(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // value a field returns to after it wraps
   function automatic logic [7:0] field_low(input int idx);
      return (idx == FI_DATE || idx == FI_MON) ? 8'h01 : 8'h00;
   endfunction

   // register index that writes a given field slot
   function automatic rtc_reg_e field_reg(input int idx);
      case (idx)
         FI_SEC:  return RG_SEC;
         FI_MIN:  return RG_MIN;
         FI_HOUR: return RG_HOUR;
         FI_DATE: return RG_DATE;
         FI_MON:  return RG_MON;
         default: return RG_YEAR;
      endcase
   endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_pkg::*;
#(
   parameter logic [7:0] LOW = 8'h00
) (
   input  logic [7:0] cur,
   input  logic [7:0] limit,
   input  logic       inc,
   output logic [7:0] nxt,
   output logic       carry
);

   // wrap at or beyond the limit so an over-range value is corrected
   assign carry = inc && (cur >= limit);

   always_comb begin
      if (!inc)       nxt = cur;
      else if (carry) nxt = LOW;
      else            nxt = bcd_step(cur);
   end

endmodule

// File: rtl/rtc_month_days.sv
module rtc_month_days #(
   parameter int YEAR_BASE = 1900
) (
   input  logic [7:0] month,
   input  logic [7:0] year,
   output logic [7:0] days
);

   // (10*hi + lo) mod 4 equals (2*hi + lo) mod 4
   logic [4:0] mod_sum;
   logic       div4;
   logic       leap;

   assign mod_sum = {year[7:4], 1'b0} + {1'b0, year[3:0]};
   assign div4    = (mod_sum[1:0] == 2'b00);

   generate
      if (YEAR_BASE == 1900) begin : g_base_1900
         // year 00 is 1900, not a leap year
         assign leap = div4 && (year != 8'h00);
      end else begin : g_base_1968
         assign leap = div4;
      end
   endgenerate

   always_comb begin
      case (month)
         8'h02:                      days = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: days = 8'h30;
         default:                    days = 8'h31;
      endcase
   end

endmodule

// File: rtl/rtc_wr_filter.sv
module rtc_wr_filter
   import rtc_pkg::*;
(
   input  rtc_reg_e   sel,
   input  logic [7:0] wdata,
   output logic       accept,
   output logic [7:0] fval
);

   logic [7:0] v7, v6, v5;

   assign v7 = {1'b0, wdata[6:0]};
   assign v6 = {2'b00, wdata[5:0]};
   assign v5 = {3'b000, wdata[4:0]};

   always_comb begin
      accept = 1'b1;
      fval   = wdata;
      case (sel)
         RG_CTRL: fval = (wdata & 8'h5F) | 8'h90;
         RG_SEC, RG_MIN: begin
            fval   = v7;
            accept = bcd_digits_ok(v7) && (v7 <= 8'h59);
         end
         RG_HOUR: begin
            fval   = v6;
            accept = bcd_digits_ok(v6) && (v6 <= 8'h23);
         end
         RG_DAY: fval = {1'b0, wdata[6], 3'b000, wdata[2:0]};
         RG_DATE: begin
            fval   = v6;
            accept = bcd_digits_ok(v6) && (v6 != 8'h00) && (v6 <= 8'h31);
         end
         RG_MON: begin
            fval   = v5;
            accept = bcd_digits_ok(v5) && (v5 != 8'h00) && (v5 <= 8'h12);
         end
         default: accept = bcd_digits_ok(wdata);
      endcase
   end

endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
   import rtc_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int YEAR_BASE = 1900
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sec_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data
);

   localparam int         SEL_W    = 3;
   localparam logic [7:0] CTRL_RST = 8'h90;

   generate
      if (ADDR_W < SEL_W) begin : g_bad_addr_w
         $error("rtc_bcd_regs: ADDR_W must be at least 3");
      end
      if (YEAR_BASE != 1900 && YEAR_BASE != 1968) begin : g_bad_base
         $error("rtc_bcd_regs: YEAR_BASE must be 1900 or 1968");
      end
   endgenerate

   logic [N_FIELD-1:0][7:0] f_q, f_nxt, f_d, f_lim;
   logic [N_FIELD:0]        inc;
   logic [7:0]              ctrl_q;
   logic                    stop_q;
   logic [2:0]              dow_q, dow_d;
   logic                    cent_q, cent_d;
   logic [7:0]              days;
   logic                    in_map, wr_hit, accept;
   logic [7:0]              fval;
   rtc_reg_e                sel;

   // address decode
   generate
      if (ADDR_W > SEL_W) begin : g_hi_dec
         assign in_map = ~|addr[ADDR_W-1:SEL_W];
      end else begin : g_no_hi
         assign in_map = 1'b1;
      end
   endgenerate

   assign sel    = rtc_reg_e'(addr[SEL_W-1:0]);
   assign wr_hit = wr_en && in_map;

   rtc_wr_filter u_filt (
      .sel    (sel),
      .wdata  (wr_data),
      .accept (accept),
      .fval   (fval)
   );

   rtc_month_days #(.YEAR_BASE(YEAR_BASE)) u_mdays (
      .month (f_q[FI_MON]),
      .year  (f_q[FI_YEAR]),
      .days  (days)
   );

   // per-field wrap limits
   assign f_lim[FI_SEC]  = 8'h59;
   assign f_lim[FI_MIN]  = 8'h59;
   assign f_lim[FI_HOUR] = 8'h23;
   assign f_lim[FI_DATE] = days;
   assign f_lim[FI_MON]  = 8'h12;
   assign f_lim[FI_YEAR] = 8'h99;

   assign inc[0] = sec_tick && !stop_q;

   // carry chain, then write override per field
   generate
      for (genvar i = 0; i < N_FIELD; i++) begin : g_field
         rtc_bcd_field #(.LOW(field_low(i))) u_fld (
            .cur   (f_q[i]),
            .limit (f_lim[i]),
            .inc   (inc[i]),
            .nxt   (f_nxt[i]),
            .carry (inc[i+1])
         );
         assign f_d[i] = (wr_hit && accept && (sel == field_reg(i))) ? fval : f_nxt[i];
      end
   endgenerate

   // day of week advances with the hour carry
   always_comb begin
      dow_d  = dow_q;
      cent_d = cent_q;
      if (inc[FI_DATE]) dow_d = (dow_q >= 3'd6) ? 3'd0 : dow_q + 3'd1;
      if (wr_hit && sel == RG_DAY) begin
         dow_d  = fval[2:0];
         cent_d = fval[6];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_q[FI_SEC]  <= 8'h00;
         f_q[FI_MIN]  <= 8'h00;
         f_q[FI_HOUR] <= 8'h00;
         f_q[FI_DATE] <= 8'h01;
         f_q[FI_MON]  <= 8'h01;
         f_q[FI_YEAR] <= 8'h00;
         ctrl_q       <= CTRL_RST;
         stop_q       <= 1'b0;
         dow_q        <= 3'd0;
         cent_q       <= 1'b0;
      end else begin
         f_q    <= f_d;
         dow_q  <= dow_d;
         cent_q <= cent_d;
         if (wr_hit && sel == RG_CTRL) ctrl_q <= fval;
         if (wr_hit && sel == RG_SEC)  stop_q <= wr_data[7];
      end
   end

   // read mux
   always_comb begin
      rd_data = 8'h00;
      if (in_map) begin
         case (sel)
            RG_CTRL: rd_data = ctrl_q;
            RG_SEC:  rd_data = {stop_q, f_q[FI_SEC][6:0]};
            RG_MIN:  rd_data = f_q[FI_MIN];
            RG_HOUR: rd_data = f_q[FI_HOUR];
            RG_DAY:  rd_data = {1'b0, cent_q, 3'b000, dow_q};
            RG_DATE: rd_data = f_q[FI_DATE];
            RG_MON:  rd_data = f_q[FI_MON];
            default: rd_data = f_q[FI_YEAR];
         endcase
      end
   end

endmodule

// File: rtl/rtc_bcd_regs_chk.sv
module rtc_bcd_regs_chk
   import rtc_pkg::*;
(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sec_tick,
   input logic                    wr_en,
   input logic                    stop,
   input logic [7:0]              ctrl,
   input logic [2:0]              dow,
   input logic [N_FIELD-1:0][7:0] fields
);

   generate
      for (genvar i = 0; i < N_FIELD; i++) begin : g_dig
         p_digits_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (fields[i][3:0] <= 4'd9) && (fields[i][7:4] <= 4'd9));
      end
   endgenerate

   p_time_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fields[FI_SEC] <= 8'h59) && (fields[FI_MIN] <= 8'h59) && (fields[FI_HOUR] <= 8'h23));

   p_cal_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fields[FI_DATE] != 8'h00) && (fields[FI_DATE] <= 8'h31) &&
      (fields[FI_MON] != 8'h00) && (fields[FI_MON] <= 8'h12));

   p_forced_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[7] && ctrl[4] && !ctrl[5]);

   p_hold_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !wr_en) |=> ($stable(fields) && $stable(dow)));

   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_tick && !wr_en) |=> ($stable(fields) && $stable(dow)));

   p_sec_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !stop && !wr_en && fields[FI_SEC] == 8'h59) |=>
      ((fields[FI_SEC] == 8'h00) && (fields[FI_MIN] != $past(fields[FI_MIN]))));

endmodule

bind rtc_bcd_regs rtc_bcd_regs_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sec_tick (sec_tick),
   .wr_en    (wr_en),
   .stop     (stop_q),
   .ctrl     (ctrl_q),
   .dow      (dow_q),
   .fields   (f_q)
);

// File: tb/sim_rtc_bcd_regs.sv
`timescale 1ns/10ps
module sim_rtc_bcd_regs;

   localparam int AW = 4;
   localparam int YB = 1900;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sec_tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wr_data = 8'h00;
   logic [7:0]    rd_data, rd1;

   int n_chk = 0;
   int n_bad = 0;

   // reference state in binary
   int m_ctrl, m_stop, m_sec, m_min, m_hr, m_dow, m_cent, m_date, m_mon, m_yr;

   always #2 clk = ~clk;

   rtc_bcd_regs #(.ADDR_W(AW), .YEAR_BASE(YB)) u0 (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

   // second build with the other year base, used only for R11
   rtc_bcd_regs #(.ADDR_W(AW), .YEAR_BASE(1968)) u1 (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr_en(wr_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd1));

   function automatic int to_bcd(input int v);
      return ((v / 10) << 4) | (v % 10);
   endfunction

   function automatic int from_bcd(input int v);
      return (v >> 4) * 10 + (v & 15);
   endfunction

   function automatic bit bcd_ok(input int v);
      return ((v & 15) <= 9) && ((v >> 4) <= 9);
   endfunction

   function automatic int mdays(input int mon, input int yr);
      bit leap;
      leap = (yr % 4 == 0) && !(YB == 1900 && yr == 0);
      if (mon == 2) return leap ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic int expect_rd(input int a);
      case (a)
         0: return m_ctrl;
         1: return (m_stop << 7) | to_bcd(m_sec);
         2: return to_bcd(m_min);
         3: return to_bcd(m_hr);
         4: return (m_cent << 6) | m_dow;
         5: return to_bcd(m_date);
         6: return to_bcd(m_mon);
         7: return to_bcd(m_yr);
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(input int a);
      case (a)
         0: return "R3";
         1: return "R4";
         2, 3: return "R5";
         4: return "R7";
         5, 6, 7: return "R6";
         default: return "R2";
      endcase
   endfunction

   task automatic model_reset();
      m_ctrl = 8'h90; m_stop = 0; m_sec = 0; m_min = 0; m_hr = 0;
      m_dow = 0; m_cent = 0; m_date = 1; m_mon = 1; m_yr = 0;
   endtask

   // tick first, then the screened write (R12)
   task automatic model_step(input bit t, input bit w, input int a, input int d);
      int v;
      if (t && m_stop == 0) begin
         if (m_sec >= 59) begin
            m_sec = 0;
            if (m_min >= 59) begin
               m_min = 0;
               if (m_hr >= 23) begin
                  m_hr = 0;
                  m_dow = (m_dow >= 6) ? 0 : m_dow + 1;
                  if (m_date >= mdays(m_mon, m_yr)) begin
                     m_date = 1;
                     if (m_mon >= 12) begin
                        m_mon = 1;
                        m_yr = (m_yr >= 99) ? 0 : m_yr + 1;
                     end else m_mon++;
                  end else m_date++;
               end else m_hr++;
            end else m_min++;
         end else m_sec++;
      end
      if (w) begin
         case (a)
            0: m_ctrl = (d & 8'h5F) | 8'h90;
            1: begin
               m_stop = (d >> 7) & 1;
               v = d & 127;
               if (bcd_ok(v) && from_bcd(v) <= 59) m_sec = from_bcd(v);
            end
            2: begin
               v = d & 127;
               if (bcd_ok(v) && from_bcd(v) <= 59) m_min = from_bcd(v);
            end
            3: begin
               v = d & 63;
               if (bcd_ok(v) && from_bcd(v) <= 23) m_hr = from_bcd(v);
            end
            4: begin m_dow = d & 7; m_cent = (d >> 6) & 1; end
            5: begin
               v = d & 63;
               if (bcd_ok(v) && from_bcd(v) >= 1 && from_bcd(v) <= 31) m_date = from_bcd(v);
            end
            6: begin
               v = d & 31;
               if (bcd_ok(v) && from_bcd(v) >= 1 && from_bcd(v) <= 12) m_mon = from_bcd(v);
            end
            7: if (bcd_ok(d & 255)) m_yr = from_bcd(d & 255);
            default: ;
         endcase
      end
   endtask

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s got %02h exp %02h", req, what, got, exp);
      end
   endtask

   // one clock: drive at negedge, release after the edge
   task automatic cycle(input bit t, input bit w, input int a, input int d);
      @(negedge clk);
      sec_tick = t; wr_en = w; addr = AW'(a); wr_data = d[7:0];
      model_step(t, w, a, d);
      @(posedge clk);
      #1;
      sec_tick = 1'b0; wr_en = 1'b0;
   endtask

   task automatic wr(input int a, input int d);
      cycle(1'b0, 1'b1, a, d);
   endtask

   task automatic tick();
      cycle(1'b1, 1'b0, 0, 0);
   endtask

   task automatic check_all(input string ctx);
      for (int a = 0; a < 10; a++) begin
         addr = AW'(a);
         #0.05;
         chk($sformatf("%s/%s", ctx, tag_of(a)), $sformatf("addr %0d", a),
             int'(rd_data), expect_rd(a));
      end
   endtask

   task automatic set_time(input int yr, input int mon, input int date,
                           input int hr, input int mn, input int sc);
      wr(7, yr); wr(6, mon); wr(5, date); wr(3, hr); wr(2, mn); wr(1, sc);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #0.5;
      check_all("R1");

      // R11: year 00, Feb 28 end of day, both bases
      set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      tick();
      check_all("R11");
      addr = AW'(5); #0.05; chk("R11", "base1968 date", int'(rd1), 8'h29);
      addr = AW'(6); #0.05; chk("R11", "base1968 month", int'(rd1), 8'h02);

      // R3 forced control bits
      wr(0, 8'hFF); check_all("R3");
      wr(0, 8'h00); check_all("R3");

      // R5/R6 rejected and accepted writes
      wr(1, 8'h60); wr(1, 8'h5A); wr(2, 8'h7F); wr(3, 8'h24); wr(3, 8'h1C);
      check_all("R5");
      wr(5, 8'h00); wr(5, 8'h32); wr(6, 8'h13); wr(6, 8'h00); wr(6, 8'h0A);
      wr(7, 8'hA0); wr(7, 8'h3F);
      check_all("R6");
      wr(3, 8'hE3); wr(5, 8'hD9); wr(6, 8'hE7); wr(7, 8'h42);
      check_all("R6");

      // R2 unmapped addresses
      wr(9, 8'h55); wr(15, 8'hFF);
      check_all("R2");

      // R9 leap year 24 and a 30-day month
      set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      tick(); check_all("R9");
      set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
      tick(); check_all("R9");
      set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      tick(); check_all("R9");
      set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
      tick(); check_all("R9");

      // R10 year wrap, century flag kept; R7 day 7 wraps
      wr(4, 8'h47);
      set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
      tick(); check_all("R10");

      // R4 hold flag
      wr(1, 8'hB0);
      tick(); tick(); check_all("R4");
      wr(1, 8'h30);
      tick(); check_all("R4");

      // R12 tick and minutes write together at a seconds wrap
      set_time(8'h05, 8'h03, 8'h10, 8'h10, 8'h20, 8'h59);
      cycle(1'b1, 1'b1, 2, 8'h10);
      check_all("R12");

      // R8 random mix of ticks and writes
      for (int n = 0; n < 4000; n++) begin
         int a, d, r;
         bit t, w;
         t = ($urandom % 3) != 0;
         w = ($urandom % 4) == 0;
         a = $urandom % 10;
         r = $urandom % 4;
         if (r == 0) d = $urandom % 256;
         else begin
            case (a)
               1: d = to_bcd($urandom % 60) | ((($urandom % 8) == 0) ? 8'h80 : 0);
               2: d = to_bcd($urandom % 60);
               3: d = to_bcd($urandom % 24);
               5: d = to_bcd(($urandom % 31) + 1);
               6: d = to_bcd(($urandom % 12) + 1);
               7: d = to_bcd($urandom % 100);
               default: d = $urandom % 256;
            endcase
         end
         if (n % 500 == 0) begin
            // jump near a month end to exercise carries
            set_time(to_bcd($urandom % 100), to_bcd(($urandom % 12) + 1),
                     8'h28, 8'h23, 8'h59, 8'h50);
         end
         cycle(t, w, a, d);
         check_all("R8");
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

endmodule